// File: doc/BRIEF.md
# Byte-Wide Flash Command Sequencer

This block models the command side of a byte-wide NOR flash placed in front of a small internal byte array. Bus writes arrive on chip-enable, write-enable and output-enable strobes that are sampled on the system clock. A write is taken when write-enable is seen rising while chip-enable is low. The sequencer decodes these writes into unlock, program, fast-program (bypass), sector erase, whole-array erase, erase hold and erase continue commands. It then runs the timed embedded operation against the array.

While an operation is running, a read returns a status byte instead of array data. Bit 7 reports completion. Bit 6 flips on every completed read, so a host can poll until two reads agree. A per-sector protect vector blocks program and erase on chosen sectors. An erase can be held so that the host can read or program the other sectors, and then continued. The reset input abandons any operation and returns to plain reads without touching committed data.

Top module: `flash_cmd_fsm`

## Requirements
- R1: After reset, reads return array contents (every byte initially FFh), and two consecutive reads of one address return the same value.
- R2: The writes AAh@555h, 55h@2AAh, A0h@555h and then data@target program the target byte once the busy period ends. Unlock addresses are compared on address bits 10:0.
- R3: While a program runs, a read returns bit 7 equal to the inverse of the programmed bit 7 and bits 5:0 equal to 0. Bit 6 inverts between successive reads.
- R4: Programming only clears bits: the stored result is the old byte AND the written byte.
- R5: A write that does not match the expected next step of a sequence returns the sequencer to plain reads, and no operation starts.
- R6: AAh@555h, 55h@2AAh, 20h@555h enters fast-program mode. In that mode, A0h at any address followed by data@target programs the target. 90h then 00h leaves the mode.
- R7: AAh@555h, 55h@2AAh, 80h@555h, AAh@555h, 55h@2AAh, 30h@sector-address erases that one sector. The sector is first cleared to 00h and then set to FFh, and other sectors keep their data. During the erase, reads return bit 7 as 0, bits 5:0 as 0, and a bit 6 that toggles.
- R8: The same five prefix writes followed by 10h@555h erase every unprotected sector.
- R9: When prot[s] is 1, program and erase aimed at sector s are refused. No busy period follows, and the data stays unchanged.
- R10: B0h at any address during an erase holds it. While held, other sectors read and program normally. Reads of a sector being erased return 80h, and programs into such a sector are refused.
- R11: 30h at any address while held continues the erase, which then completes.
- R12: Reset low abandons a running program (the byte is not changed) or erase (bytes already walked stay as written). Afterwards reads return data and commands are accepted.
- R13: Sector map with the default top-boot layout: sector 0 = 000h-3FFh, sector 1 = 400h-5FFh, sector 2 = 600h-6FFh, sector 3 = 700h-7FFh.
- R14: Writes during a busy period are ignored, except B0h during an erase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the bus strobes |
| rst_n | input | 1 | Asynchronous active-low reset; aborts operations |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low; rising edge takes the write |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Byte address |
| din | input | 8 | Write data / command code |
| prot | input | NUM_SECT | Per-sector protect, 1 = protected |
| dout | output | 8 | Read data or status, 0 when not reading |

## Verification
The checker assumes that the strobes, address and data are synchronous to the clock, and that address and data hold steady from the write-enable fall until after its rise is sampled. It also assumes that reads and writes never overlap, and that the protect vector does not change while an operation it governs is running. The bench drives every signal on the falling clock edge, holds each strobe phase for at least one full cycle, and changes prot only while the sequencer is idle. The bench keeps a byte-level model of the array, computed from sector boundaries and AND-programming. It compares full-array read sweeps against that model.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

   typedef enum logic [3:0] {
      SQ_IDLE, SQ_U1, SQ_U2, SQ_PGM, SQ_E1, SQ_E2, SQ_E3, SQ_BX,
      SQ_PBUSY, SQ_EBUSY
   } seq_t;

   typedef enum logic [1:0] {MD_READ, MD_BYP, MD_SUSP} mode_t;

   typedef enum logic [1:0] {PH_PRE, PH_ERS, PH_WAIT} phase_t;

   localparam logic [10:0] UNLK_ADDR1 = 11'h555;
   localparam logic [10:0] UNLK_ADDR2 = 11'h2AA;
   localparam logic [7:0]  CODE_UNLK1 = 8'hAA;
   localparam logic [7:0]  CODE_UNLK2 = 8'h55;
   localparam logic [7:0]  CODE_PROG  = 8'hA0;
   localparam logic [7:0]  CODE_ERASE = 8'h80;
   localparam logic [7:0]  CODE_SECT  = 8'h30;
   localparam logic [7:0]  CODE_CHIP  = 8'h10;
   localparam logic [7:0]  CODE_HOLD  = 8'hB0;
   localparam logic [7:0]  CODE_CONT  = 8'h30;
   localparam logic [7:0]  CODE_FAST  = 8'h20;
   localparam logic [7:0]  CODE_FX1   = 8'h90;
   localparam logic [7:0]  CODE_FX2   = 8'h00;

endpackage

// File: rtl/flash_sector_dec.sv
module flash_sector_dec #(
   parameter int NUM_SECT = 4,
   parameter bit BOOT_TOP = 1'b1,
   localparam int NB = NUM_SECT - 1,
   localparam int SW = (NUM_SECT > 1) ? $clog2(NUM_SECT) : 1
) (
   input  logic [NB-1:0] top_bits,
   output logic [SW-1:0] sect
);
   // Leading run of a fixed level in the upper address bits picks the sector;
   // each extra bit of the run halves the sector size.
   logic [SW-1:0] run_len;

   always_comb begin
      logic going;
      going   = 1'b1;
      run_len = '0;
      for (int i = 0; i < NB; i++) begin
         if (going && (top_bits[NB-1-i] == BOOT_TOP)) run_len = run_len + 1'b1;
         else going = 1'b0;
      end
   end

   generate
      if (BOOT_TOP) begin : g_top_boot
         assign sect = run_len;
      end else begin : g_bottom_boot
         assign sect = SW'(NB) - run_len;
      end
   endgenerate

endmodule

// File: rtl/flash_op_timer.sv
module flash_op_timer #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         run,
   output logic         expired
);
   logic [W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                cnt <= '0;
      else if (load)             cnt <= load_val;
      else if (run && cnt != '0) cnt <= cnt - 1'b1;
   end

   assign expired = (cnt == '0);

endmodule

// File: rtl/flash_array.sv
module flash_array #(
   parameter int ADDR_W = 11,
   localparam int DEPTH = 1 << ADDR_W
) (
   input  logic              clk,
   input  logic              we,
   input  logic              and_mode,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [7:0]        wdata,
   input  logic [ADDR_W-1:0] raddr,
   output logic [7:0]        rdata
);
   logic [7:0] cells [DEPTH];

   initial begin
      for (int i = 0; i < DEPTH; i++) cells[i] = 8'hFF;
   end

   always_ff @(posedge clk) begin
      if (we) cells[waddr] <= and_mode ? (cells[waddr] & wdata) : wdata;
   end

   assign rdata = cells[raddr];

endmodule

// File: rtl/flash_cmd_fsm.sv
module flash_cmd_fsm
   import flash_cmd_pkg::*;
#(
   parameter int ADDR_W    = 11,
   parameter int NUM_SECT  = 4,
   parameter bit BOOT_TOP  = 1'b1,
   parameter int PROG_CYC  = 40,
   parameter int ERASE_CYC = 64
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                ce_n,
   input  logic                we_n,
   input  logic                oe_n,
   input  logic [ADDR_W-1:0]   addr,
   input  logic [7:0]          din,
   input  logic [NUM_SECT-1:0] prot,
   output logic [7:0]          dout
);
   localparam int NB   = NUM_SECT - 1;
   localparam int SW   = (NUM_SECT > 1) ? $clog2(NUM_SECT) : 1;
   localparam int TMAX = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
   localparam int TW   = $clog2(TMAX + 1);

   initial begin
      assert (ADDR_W >= 11) else $fatal(1, "ADDR_W must cover the unlock addresses");
      assert (NUM_SECT >= 2 && NB <= ADDR_W) else $fatal(1, "bad NUM_SECT");
      assert (PROG_CYC >= 1 && ERASE_CYC >= 1) else $fatal(1, "busy counts must be >= 1");
   end

   seq_t                seq;
   mode_t               mode;
   phase_t              ph;
   logic [ADDR_W-1:0]   ptr, pa;
   logic [7:0]          pd;
   logic [NUM_SECT-1:0] emask, start_mask, sel_mask;
   logic [SW-1:0]       bus_sect, walk_sect;
   logic                we_q, rd_q, tog;
   logic                wr_ev, rd_act, is_a1, is_a2, unlk1, unlk2, wr_hold;
   logic                prog_busy, erase_busy, suspended, prog_ok;
   logic                p_load, p_exp, e_load, e_run, e_exp, walk_go, prog_done;
   logic                arr_we, arr_and;
   logic [ADDR_W-1:0]   arr_waddr;
   logic [7:0]          arr_wdata, arr_rdata;

   // ---- bus strobes
   assign wr_ev  = !ce_n && we_n && !we_q;
   assign rd_act = !ce_n && !oe_n;
   assign is_a1  = (addr[10:0] == UNLK_ADDR1);
   assign is_a2  = (addr[10:0] == UNLK_ADDR2);
   assign unlk1  = is_a1 && (din == CODE_UNLK1);
   assign unlk2  = is_a2 && (din == CODE_UNLK2);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         we_q <= 1'b1;
         rd_q <= 1'b0;
         tog  <= 1'b0;
      end else begin
         we_q <= we_n;
         rd_q <= rd_act;
         if (rd_q && !rd_act) tog <= ~tog;
      end
   end

   // ---- sector decode
   flash_sector_dec #(.NUM_SECT(NUM_SECT), .BOOT_TOP(BOOT_TOP)) u_bus_dec (
      .top_bits(addr[ADDR_W-1 -: NB]), .sect(bus_sect));
   flash_sector_dec #(.NUM_SECT(NUM_SECT), .BOOT_TOP(BOOT_TOP)) u_walk_dec (
      .top_bits(ptr[ADDR_W-1 -: NB]), .sect(walk_sect));

   assign prog_busy  = (seq == SQ_PBUSY);
   assign erase_busy = (seq == SQ_EBUSY);
   assign suspended  = (mode == MD_SUSP);
   assign wr_hold    = wr_ev && (din == CODE_HOLD);
   assign prog_ok    = !prot[bus_sect] && !(suspended && emask[bus_sect]);

   always_comb begin
      sel_mask = '0;
      if (din == CODE_SECT)             sel_mask = NUM_SECT'(1) << bus_sect;
      else if (din == CODE_CHIP && is_a1) sel_mask = '1;
      start_mask = sel_mask & ~prot;
   end

   // ---- busy timers
   assign p_load = (seq == SQ_PGM) && wr_ev && prog_ok;
   assign walk_go = erase_busy && !wr_hold && (ph != PH_WAIT);
   assign e_load = walk_go && (ph == PH_ERS) && (&ptr);
   assign e_run  = erase_busy && (ph == PH_WAIT) && !wr_hold;

   flash_op_timer #(.W(TW)) u_prog_tmr (
      .clk(clk), .rst_n(rst_n), .load(p_load), .load_val(TW'(PROG_CYC)),
      .run(prog_busy), .expired(p_exp));
   flash_op_timer #(.W(TW)) u_erase_tmr (
      .clk(clk), .rst_n(rst_n), .load(e_load), .load_val(TW'(ERASE_CYC)),
      .run(e_run), .expired(e_exp));

   // ---- array write port: program commit or erase walker
   assign prog_done = prog_busy && p_exp;
   assign arr_we    = prog_done || (walk_go && emask[walk_sect]);
   assign arr_and   = prog_done;
   assign arr_waddr = prog_done ? pa : ptr;
   assign arr_wdata = prog_done ? pd : ((ph == PH_PRE) ? 8'h00 : 8'hFF);

   flash_array #(.ADDR_W(ADDR_W)) u_array (
      .clk(clk), .we(arr_we), .and_mode(arr_and), .waddr(arr_waddr),
      .wdata(arr_wdata), .raddr(addr), .rdata(arr_rdata));

   // ---- command sequencer
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seq   <= SQ_IDLE;
         mode  <= MD_READ;
         ph    <= PH_PRE;
         ptr   <= '0;
         emask <= '0;
         pa    <= '0;
         pd    <= 8'hFF;
      end else begin
         case (seq)
            SQ_PBUSY: if (p_exp) seq <= SQ_IDLE;
            SQ_EBUSY: begin
               if (wr_hold) begin
                  seq  <= SQ_IDLE;
                  mode <= MD_SUSP;
               end else if (ph == PH_WAIT) begin
                  if (e_exp) begin
                     seq   <= SQ_IDLE;
                     emask <= '0;
                     ph    <= PH_PRE;
                  end
               end else begin
                  ptr <= ptr + 1'b1;
                  if (&ptr) ph <= (ph == PH_PRE) ? PH_ERS : PH_WAIT;
               end
            end
            SQ_IDLE: if (wr_ev) begin
               case (mode)
                  MD_BYP: begin
                     if (din == CODE_PROG)     seq <= SQ_PGM;
                     else if (din == CODE_FX1) seq <= SQ_BX;
                  end
                  MD_SUSP: begin
                     if (din == CODE_CONT) begin
                        seq  <= SQ_EBUSY;
                        mode <= MD_READ;
                     end else if (unlk1) seq <= SQ_U1;
                  end
                  default: if (unlk1) seq <= SQ_U1;
               endcase
            end
            SQ_U1: if (wr_ev) seq <= unlk2 ? SQ_U2 : SQ_IDLE;
            SQ_U2: if (wr_ev) begin
               seq <= SQ_IDLE;
               if (is_a1 && din == CODE_PROG) seq <= SQ_PGM;
               else if (is_a1 && din == CODE_ERASE && mode == MD_READ) seq <= SQ_E1;
               else if (is_a1 && din == CODE_FAST && mode == MD_READ) mode <= MD_BYP;
            end
            SQ_PGM: if (wr_ev) begin
               if (prog_ok) begin
                  seq <= SQ_PBUSY;
                  pa  <= addr;
                  pd  <= din;
               end else seq <= SQ_IDLE;
            end
            SQ_E1: if (wr_ev) seq <= unlk1 ? SQ_E2 : SQ_IDLE;
            SQ_E2: if (wr_ev) seq <= unlk2 ? SQ_E3 : SQ_IDLE;
            SQ_E3: if (wr_ev) begin
               seq <= SQ_IDLE;
               if (start_mask != '0) begin
                  seq   <= SQ_EBUSY;
                  emask <= start_mask;
                  ptr   <= '0;
                  ph    <= PH_PRE;
               end
            end
            SQ_BX: if (wr_ev) begin
               seq <= SQ_IDLE;
               if (din == CODE_FX2) mode <= MD_READ;
            end
            default: seq <= SQ_IDLE;
         endcase
      end
   end

   // ---- read path
   always_comb begin
      if (!rd_act)                          dout = 8'h00;
      else if (prog_busy)                   dout = {~pd[7], tog, 6'b0};
      else if (erase_busy)                  dout = {1'b0, tog, 6'b0};
      else if (suspended && emask[bus_sect]) dout = 8'h80;
      else                                  dout = arr_rdata;
   end

endmodule

// File: rtl/flash_cmd_fsm_chk.sv
module flash_cmd_fsm_chk #(
   parameter int NUM_SECT = 4,
   parameter int SW = 2
) (
   input logic                clk,
   input logic                rst_n,
   input logic [NUM_SECT-1:0] prot,
   input logic [7:0]          dout,
   input logic                rd_act,
   input logic                wr_ev,
   input logic                prog_busy,
   input logic                erase_busy,
   input logic                suspended,
   input logic                arr_we,
   input logic                arr_and,
   input logic [SW-1:0]       bus_sect,
   input logic [SW-1:0]       walk_sect
);
   // R14: a busy period only begins from a sampled bus write
   a_r14_prog_from_write: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(prog_busy) |-> $past(wr_ev));
   a_r14_erase_from_write: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(erase_busy) |-> $past(wr_ev));

   // R3: status byte keeps bits 5:0 low, bit 6 steady within one read
   a_r3_status_low: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_act && (prog_busy || erase_busy)) |-> (dout[5:0] == 6'b0));
   a_r3_toggle_steady: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_act && prog_busy && $past(rd_act) && $past(prog_busy)) |-> $stable(dout[6]));

   // R7: erase polling bit reads 0 while erasing
   a_r7_erase_dq7: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_act && erase_busy) |-> !dout[7]);

   // R9: protected sectors are never written
   a_r9_prot_prog: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(prog_busy) |-> !$past(prot[bus_sect]));
   a_r9_prot_erase: assert property (@(posedge clk) disable iff (!rst_n)
      (arr_we && !arr_and) |-> !prot[walk_sect]);

   // R10: a held erase does not touch the array
   a_r10_hold_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (suspended && !prog_busy) |-> !arr_we);

endmodule

bind flash_cmd_fsm flash_cmd_fsm_chk #(.NUM_SECT(NUM_SECT), .SW(SW)) chk_i (
   .clk(clk), .rst_n(rst_n), .prot(prot), .dout(dout), .rd_act(rd_act),
   .wr_ev(wr_ev), .prog_busy(prog_busy), .erase_busy(erase_busy),
   .suspended(suspended), .arr_we(arr_we), .arr_and(arr_and),
   .bus_sect(bus_sect), .walk_sect(walk_sect));

// File: tb/flash_cmd_fsm_tb_top.sv
module flash_cmd_fsm_tb_top;
   localparam int AW = 11;
   localparam int NS = 4;
   localparam int DEPTH = 1 << AW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
   logic [AW-1:0] addr = '0;
   logic [7:0]    din = '0;
   logic [NS-1:0] prot = '0;
   logic [7:0]    dout;

   int  nchk = 0, nerr = 0;
   bit  finished = 1'b0;
   logic [7:0] model [DEPTH];

   always #10 clk = ~clk;

   flash_cmd_fsm #(.ADDR_W(AW), .NUM_SECT(NS), .BOOT_TOP(1'b1),
                   .PROG_CYC(40), .ERASE_CYC(64)) dut_i (
      .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
      .addr(addr), .din(din), .prot(prot), .dout(dout));

   function automatic int sect_of(input int a);
      if (a < 1024) return 0;
      if (a < 1536) return 1;
      if (a < 1792) return 2;
      return 3;
   endfunction

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      nchk++;
      if (!ok) begin
         nerr++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic bus_write(input int a, input int d);
      @(negedge clk);
      addr = AW'(a); din = 8'(d); ce_n = 1'b0; we_n = 1'b0;
      @(negedge clk);
      we_n = 1'b1;
      @(negedge clk);
      ce_n = 1'b1;
   endtask

   task automatic bus_read(input int a, output logic [7:0] d);
      @(negedge clk);
      addr = AW'(a); ce_n = 1'b0; oe_n = 1'b0;
      @(negedge clk);
      d = dout;
      oe_n = 1'b1; ce_n = 1'b1;
   endtask

   task automatic unlock();
      bus_write('h555, 'hAA);
      bus_write('h2AA, 'h55);
   endtask

   task automatic prog4(input int a, input int d);
      unlock();
      bus_write('h555, 'hA0);
      bus_write(a, d);
   endtask

   task automatic erase_cmd(input int a, input int code);
      unlock();
      bus_write('h555, 'h80);
      unlock();
      bus_write(a, code);
   endtask

   task automatic wait_ready(input int a, input int maxit, output bit ok);
      logic [7:0] r1, r2;
      ok = 1'b0;
      for (int i = 0; i < maxit && !ok; i++) begin
         bus_read(a, r1);
         bus_read(a, r2);
         if (r1 == r2) ok = 1'b1;
      end
   endtask

   task automatic sweep(input string tag);
      logic [7:0] r;
      int bad = 0, first_a = -1, first_v = 0;
      for (int a = 0; a < DEPTH; a++) begin
         bus_read(a, r);
         if (r !== model[a]) begin
            if (first_a < 0) begin first_a = a; first_v = int'(r); end
            bad++;
         end
      end
      if (first_a < 0) check(1'b1, tag, 0, 0);
      else check(1'b0, $sformatf("%s addr=%0h", tag, first_a), first_v, int'(model[first_a]));
   endtask

   task automatic model_erase(input int s, input logic [7:0] v);
      for (int a = 0; a < DEPTH; a++) if (sect_of(a) == s) model[a] = v;
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      end
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      nchk++; nerr++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
   end

   initial begin
      logic [7:0] r, r2;
      bit ok;
      for (int a = 0; a < DEPTH; a++) model[a] = 8'hFF;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state reads erased array, stable
      bus_read('h000, r);  check(r == 8'hFF, "R1 read 000", r, 'hFF);
      bus_read('h7FF, r);  bus_read('h7FF, r2);
      check(r == 8'hFF && r2 == r, "R1 stable 7FF", r2, 'hFF);

      // R2/R3: four-write program with status polling
      prog4('h123, 'h5A);
      bus_read('h123, r); bus_read('h123, r2);
      check((r & 8'hBF) == 8'h80, "R3 program status", r, 'h80);
      check(r[6] != r2[6] && (r2 & 8'hBF) == 8'h80, "R3 toggle", r2, {1'b1, ~r[6], 6'b0});
      wait_ready('h123, 100, ok); check(ok, "R3 completes", 0, 1);
      model['h123] = 8'h5A;
      bus_read('h123, r); check(r == 8'h5A, "R2 programmed", r, 'h5A);

      // R4: AND programming
      prog4('h123, 'hF0); wait_ready('h123, 100, ok);
      model['h123] = 8'h50;
      bus_read('h123, r); check(r == 8'h50, "R4 and-only", r, 'h50);

      // R5: broken sequences
      bus_write('h555, 'hAA); bus_write('h2AB, 'h55);
      bus_write('h555, 'hA0); bus_write('h200, 'h00);
      bus_read('h200, r); bus_read('h200, r2);
      check(r == 8'hFF && r2 == 8'hFF, "R5 bad addr step2", r, 'hFF);
      unlock(); bus_write('h555, 'h77); bus_write('h201, 'h00);
      bus_read('h201, r); check(r == 8'hFF, "R5 bad code step3", r, 'hFF);
      prog4('h201, 'h0F); wait_ready('h201, 100, ok);
      model['h201] = 8'h0F;
      bus_read('h201, r); check(r == 8'h0F, "R5 recovers", r, 'h0F);

      // R14: write during busy ignored
      prog4('h300, 'hAA);
      bus_write('h555, 'hAA);
      wait_ready('h300, 100, ok);
      bus_write('h2AA, 'h55); bus_write('h555, 'hA0); bus_write('h301, 'h00);
      model['h300] = 8'hAA;
      bus_read('h301, r); check(r == 8'hFF, "R14 busy write ignored", r, 'hFF);
      bus_read('h300, r); check(r == 8'hAA, "R14 program intact", r, 'hAA);

      // R6: fast-program mode
      unlock(); bus_write('h555, 'h20);
      bus_write('h000, 'hA0); bus_write('h400, 'h33); wait_ready('h400, 100, ok);
      bus_write('h7AB, 'hA0); bus_write('h401, 'h44); wait_ready('h401, 100, ok);
      model['h400] = 8'h33; model['h401] = 8'h44;
      bus_read('h400, r); check(r == 8'h33, "R6 two-write program", r, 'h33);
      bus_read('h401, r); check(r == 8'h44, "R6 second program", r, 'h44);
      bus_write('h000, 'h90); bus_write('h000, 'h00);
      bus_write('h000, 'hA0); bus_write('h402, 'h00);
      bus_read('h402, r); check(r == 8'hFF, "R6 mode left", r, 'hFF);

      // R9: protection
      prot = 4'b0100;
      prog4('h650, 'h00);
      bus_read('h650, r); bus_read('h650, r2);
      check(r == 8'hFF && r2 == 8'hFF, "R9 program refused", r, 'hFF);
      erase_cmd('h600, 'h30);
      bus_read('h123, r); bus_read('h123, r2);
      check(r == 8'h50 && r2 == 8'h50, "R9 erase refused", r, 'h50);
      prot = '0;

      // R7: sector erase of sector 1
      prog4('h7F0, 'h12); wait_ready('h7F0, 100, ok); model['h7F0] = 8'h12;
      erase_cmd('h4AA, 'h30);
      bus_read('h000, r); bus_read('h000, r2);
      check((r & 8'hBF) == 8'h00 && r2[6] != r[6], "R7 erase status", r2, {1'b0, ~r[6], 6'b0});
      wait_ready('h000, 3000, ok); check(ok, "R7 erase completes", 0, 1);
      model_erase(1, 8'hFF);
      sweep("R7 sector erase sweep");

      // R10/R11: hold and continue
      erase_cmd('h010, 'h30);
      repeat (100) @(negedge clk);
      bus_write('h000, 'hB0);
      bus_read('h123, r); check(r == 8'h80, "R10 held sector reads 80", r, 'h80);
      bus_read('h7F0, r); check(r == 8'h12, "R10 other sector data", r, 'h12);
      prog4('h7F1, 'h21); wait_ready('h7F1, 100, ok); model['h7F1] = 8'h21;
      bus_read('h7F1, r); check(r == 8'h21, "R10 program while held", r, 'h21);
      prog4('h124, 'h00);
      bus_read('h7F0, r); check(r == 8'h12, "R10 held-sector program refused", r, 'h12);
      bus_write('h000, 'h30);
      bus_read('h7F0, r); check((r & 8'hBF) == 8'h00, "R11 erase resumed busy", r, 0);
      wait_ready('h7F0, 3000, ok); check(ok, "R11 erase completes", 0, 1);
      model_erase(0, 8'hFF);
      sweep("R11 sweep after continue");

      // R13: sector boundaries
      prog4('h3FF, 'h01); wait_ready('h3FF, 100, ok);
      prog4('h400, 'h02); wait_ready('h400, 100, ok);
      prog4('h5FF, 'h03); wait_ready('h5FF, 100, ok);
      prog4('h6FF, 'h04); wait_ready('h6FF, 100, ok);
      prog4('h700, 'h05); wait_ready('h700, 100, ok);
      prog4('h7FF, 'h06); wait_ready('h7FF, 100, ok);
      model['h3FF] = 8'h01; model['h400] = 8'h02; model['h5FF] = 8'h03;
      model['h6FF] = 8'h04; model['h700] = 8'h05; model['h7FF] = 8'h06;
      erase_cmd('h600, 'h30); wait_ready('h000, 3000, ok);
      model_erase(2, 8'hFF);
      bus_read('h5FF, r); check(r == 8'h03, "R13 5FF in sector1", r, 'h03);
      bus_read('h6FF, r); check(r == 8'hFF, "R13 6FF in sector2", r, 'hFF);
      bus_read('h700, r); check(r == 8'h05, "R13 700 in sector3", r, 'h05);
      erase_cmd('h7FF, 'h30); wait_ready('h000, 3000, ok);
      model_erase(3, 8'hFF);
      sweep("R13 boundary sweep");

      // R8: whole-array erase with sector 3 protected
      prog4('h7A0, 'h00); wait_ready('h7A0, 100, ok); model['h7A0] = 8'h00;
      prot = 4'b1000;
      erase_cmd('h555, 'h10); wait_ready('h000, 3000, ok);
      check(ok, "R8 chip erase completes", 0, 1);
      for (int a = 0; a < DEPTH; a++) if (sect_of(a) != 3) model[a] = 8'hFF;
      sweep("R8 chip erase sweep");
      prot = '0;

      // R12: reset aborts program
      prog4('h010, 'h00);
      @(negedge clk); rst_n = 1'b0; @(negedge clk); rst_n = 1'b1;
      bus_read('h010, r); bus_read('h010, r2);
      check(r == 8'hFF && r2 == 8'hFF, "R12 program abandoned", r, 'hFF);

      // R12/R7: reset during erase walk exposes preprogrammed zeros
      erase_cmd('h7C0, 'h30);
      repeat (2200) @(negedge clk);
      rst_n = 1'b0; @(negedge clk); rst_n = 1'b1;
      model_erase(3, 8'h00);
      prog4('h011, 'h0F); wait_ready('h011, 100, ok); model['h011] = 8'h0F;
      bus_read('h011, r); check(r == 8'h0F, "R12 command after reset", r, 'h0F);
      sweep("R12 R7 preprogram sweep");

      summary();
      $finish;
   end

endmodule